// File: doc/BRIEF.md
# Burst Scheduler with Detection Integrator

This block paces the acquisition bursts of a sensing front end and decides when a detection is genuine. It requests a burst and waits for the front end to report that the burst has finished. With that report comes a one-bit verdict saying whether the measured signal was past the detection threshold. The block then waits a number of slow-timebase ticks before it requests the next burst. It also keeps a run counter of consecutive over-threshold verdicts, and raises its detect output once that run reaches a programmable target.

The wait between bursts is set by a sleep-count setting. That setting is multiplied by a fixed number of ticks per sleep interval. A sleep count of zero selects a short fixed gap instead. An optional fast mode shortens the wait to that same short gap while a candidate detection is still being confirmed. In fast mode, confirmation time therefore depends on the target and not on the sleep count. Normal spacing returns once the detect output is up or the run is broken.

The analog measurement and the threshold comparison sit outside the block. The integrating logic supplies the tick strobe and the settings. The settings are sampled only when a burst result arrives.

Top module: `acq_burst_confirm`

## Requirements
- R1: While reset is held, `det_out` and `burst_req` are 0. The first clock edge after reset release moves the block to request a burst, so `burst_req` is 1 during the first cycle after that edge.
- R2: `burst_req` is high for exactly one cycle. No further request is made until a `burst_done` has been accepted for the outstanding burst.
- R3: After a burst result is accepted with `sc_cfg` > 0 and no fast confirmation in progress, exactly `sc_cfg` × SLEEP_TICKS tick pulses pass before the next `burst_req`.
- R4: After a burst result is accepted with `sc_cfg` = 0, exactly GAP_TICKS tick pulses pass before the next `burst_req`, in either mode.
- R5: `det_out` rises in the cycle after the `burst_done` that carries the `dit_cfg`-th consecutive over-threshold result. It stays high while later results stay over threshold.
- R6: A burst result with `over_thr` = 0 clears the run count. If `det_out` was high, it falls in the cycle after that `burst_done`.
- R7: A `dit_cfg` of 0 acts as a target of 1, so a single over-threshold result raises `det_out`.
- R8: With `fast_cfg` = 1, a result that leaves the run count at 1 or more while `det_out` stays low is followed by a wait of GAP_TICKS ticks, whatever `sc_cfg` is. Once `det_out` is high or the run is cleared, the R3/R4 spacing applies again.
- R9: A `burst_done` pulse that arrives while no burst is outstanding is ignored. It changes neither `det_out`, nor the run count, nor the length of the wait in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle strobe of the slow timebase that counts sleep and gap time |
| burst_done | input | 1 | One-cycle strobe: the requested burst has finished |
| over_thr | input | 1 | Threshold verdict of the finished burst, valid with `burst_done` |
| sc_cfg | input | SC_W | Sleep intervals between bursts (0 selects the short gap) |
| dit_cfg | input | DIT_W | Consecutive over-threshold results needed to raise `det_out` |
| fast_cfg | input | 1 | 1 selects short-gap spacing during confirmation |
| burst_req | output | 1 | One-cycle request to start a burst |
| det_out | output | 1 | Registered confirmed-detection output |

## Verification
The assertions assume that `burst_done` is a single-cycle strobe, that `over_thr` and the three settings are valid in the cycle `burst_done` is high, and that `tick` is a single-cycle strobe. The bench drives all of these on the falling clock edge. It raises `burst_done` only for one cycle, with settings and verdict set up in that same cycle. It generates ticks as isolated pulses every third cycle. The one stray `burst_done` it produces is aimed at the wait phase, to exercise R9.

// File: rtl/acq_pkg.sv
package acq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_REQ,
    ST_BUSY,
    ST_WAIT
  } acq_state_e;
endpackage

// File: rtl/acq_integrator.sv
module acq_integrator #(
  parameter int DIT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sample,
  input  logic             over,
  input  logic [DIT_W-1:0] dit,
  output logic             det_q,
  output logic             confirm_nxt
);
  logic [DIT_W-1:0] cnt_q, cnt_nxt, tgt;
  logic             det_nxt;

  // a target of zero behaves as one
  function automatic logic [DIT_W-1:0] eff_target(input logic [DIT_W-1:0] d);
    return (d == '0) ? DIT_W'(1) : d;
  endfunction

  always_comb begin
    tgt = eff_target(dit);
    if (!over)             cnt_nxt = '0;
    else if (cnt_q >= tgt) cnt_nxt = cnt_q;
    else                   cnt_nxt = cnt_q + DIT_W'(1);
    det_nxt     = over && (cnt_nxt >= tgt);
    confirm_nxt = over && !det_nxt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      det_q <= 1'b0;
    end else if (sample) begin
      cnt_q <= cnt_nxt;
      det_q <= det_nxt;
    end
  end
endmodule

// File: rtl/acq_gap_timer.sv
module acq_gap_timer #(
  parameter int SC_W        = 8,
  parameter int SLEEP_TICKS = 4,
  parameter int GAP_TICKS   = 2,
  localparam int MAX_WAIT   = (2**SC_W - 1) * SLEEP_TICKS + GAP_TICKS,
  localparam int WAIT_W     = $clog2(MAX_WAIT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [SC_W-1:0]   sc,
  input  logic              short_gap,
  input  logic              tick,
  input  logic              waiting,
  output logic [WAIT_W-1:0] load_len,
  output logic              expire
);
  logic [WAIT_W-1:0] cnt_q;

  function automatic logic [WAIT_W-1:0] wait_ticks(input logic [SC_W-1:0] s,
                                                   input logic            shrt);
    if (shrt || s == '0) return WAIT_W'(GAP_TICKS);
    return WAIT_W'(s) * WAIT_W'(SLEEP_TICKS);
  endfunction

  assign load_len = wait_ticks(sc, short_gap);
  assign expire   = waiting && tick && (cnt_q == WAIT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n)                                     cnt_q <= '0;
    else if (load)                                  cnt_q <= load_len;
    else if (waiting && tick && cnt_q > WAIT_W'(1)) cnt_q <= cnt_q - WAIT_W'(1);
  end
endmodule

// File: rtl/acq_burst_confirm.sv
module acq_burst_confirm #(
  parameter int SC_W        = 8,
  parameter int DIT_W       = 8,
  parameter int SLEEP_TICKS = 4,
  parameter int GAP_TICKS   = 2,
  localparam int MAX_WAIT   = (2**SC_W - 1) * SLEEP_TICKS + GAP_TICKS,
  localparam int WAIT_W     = $clog2(MAX_WAIT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             burst_done,
  input  logic             over_thr,
  input  logic [SC_W-1:0]  sc_cfg,
  input  logic [DIT_W-1:0] dit_cfg,
  input  logic             fast_cfg,
  output logic             burst_req,
  output logic             det_out
);
  import acq_pkg::*;

  acq_state_e        state_q, state_d;
  logic              busy, waiting, sample, expire, confirm_nxt;
  logic [WAIT_W-1:0] load_len;

  assign busy      = (state_q == ST_BUSY);
  assign waiting   = (state_q == ST_WAIT);
  assign sample    = busy && burst_done;
  assign burst_req = (state_q == ST_REQ);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: state_d = ST_REQ;
      ST_REQ:  state_d = ST_BUSY;
      ST_BUSY: if (sample) state_d = ST_WAIT;
      ST_WAIT: if (expire) state_d = ST_REQ;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  acq_integrator #(.DIT_W(DIT_W)) i_integ (
    .clk         (clk),
    .rst_n       (rst_n),
    .sample      (sample),
    .over        (over_thr),
    .dit         (dit_cfg),
    .det_q       (det_out),
    .confirm_nxt (confirm_nxt)
  );

  acq_gap_timer #(
    .SC_W        (SC_W),
    .SLEEP_TICKS (SLEEP_TICKS),
    .GAP_TICKS   (GAP_TICKS)
  ) i_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (sample),
    .sc        (sc_cfg),
    .short_gap (fast_cfg && confirm_nxt),
    .tick      (tick),
    .waiting   (waiting),
    .load_len  (load_len),
    .expire    (expire)
  );
endmodule

// File: rtl/acq_burst_confirm_chk.sv
module acq_burst_confirm_chk #(
  parameter int SC_W        = 8,
  parameter int DIT_W       = 8,
  parameter int SLEEP_TICKS = 4,
  parameter int GAP_TICKS   = 2,
  parameter int WAIT_W      = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              burst_req,
  input logic              busy,
  input logic              sample,
  input logic              over_thr,
  input logic              fast_cfg,
  input logic [SC_W-1:0]   sc_cfg,
  input logic [DIT_W-1:0]  dit_cfg,
  input logic [WAIT_W-1:0] load_len,
  input logic              det_out
);
  p_req_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    burst_req |=> (!burst_req && busy));

  p_stray_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !sample |=> $stable(det_out));

  p_low_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sample && !over_thr) |=> !det_out);

  p_rise_after_over_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(det_out) |-> $past(sample && over_thr));

  p_unit_target_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sample && over_thr && dit_cfg <= 1) |=> det_out);

  p_short_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sample && sc_cfg == 0) |-> (load_len == WAIT_W'(GAP_TICKS)));

  p_sleep_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sample && sc_cfg != 0 && !fast_cfg) |->
      (load_len == WAIT_W'(sc_cfg) * WAIT_W'(SLEEP_TICKS)));
endmodule

bind acq_burst_confirm acq_burst_confirm_chk #(
  .SC_W        (SC_W),
  .DIT_W       (DIT_W),
  .SLEEP_TICKS (SLEEP_TICKS),
  .GAP_TICKS   (GAP_TICKS),
  .WAIT_W      (WAIT_W)
) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .burst_req (burst_req),
  .busy      (busy),
  .sample    (sample),
  .over_thr  (over_thr),
  .fast_cfg  (fast_cfg),
  .sc_cfg    (sc_cfg),
  .dit_cfg   (dit_cfg),
  .load_len  (load_len),
  .det_out   (det_out)
);

// File: tb/test_acq_burst_confirm.sv
module test_acq_burst_confirm;
  localparam int CLK_PERIOD = 10;
  localparam int SLEEP      = 4;
  localparam int GAP        = 2;

  typedef struct packed {
    logic        over;
    logic [7:0]  sc;
    logic [7:0]  dit;
    logic        fast;
    logic        out;
    logic [11:0] gap;
    logic [3:0]  rq_out;
    logic [3:0]  rq_gap;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 8'd1,   8'd3, 1'b0, 1'b0, 12'd4,    4'd6, 4'd3}, // R6 R3
    '{1'b1, 8'd2,   8'd3, 1'b0, 1'b0, 12'd8,    4'd5, 4'd3}, // R5
    '{1'b1, 8'd2,   8'd3, 1'b0, 1'b0, 12'd8,    4'd5, 4'd3},
    '{1'b1, 8'd2,   8'd3, 1'b0, 1'b1, 12'd8,    4'd5, 4'd3}, // third in a row
    '{1'b1, 8'd2,   8'd3, 1'b0, 1'b1, 12'd8,    4'd5, 4'd3},
    '{1'b0, 8'd2,   8'd3, 1'b0, 1'b0, 12'd8,    4'd6, 4'd3},
    '{1'b1, 8'd3,   8'd3, 1'b1, 1'b0, 12'd2,    4'd5, 4'd8}, // R8 fast
    '{1'b1, 8'd3,   8'd3, 1'b1, 1'b0, 12'd2,    4'd5, 4'd8},
    '{1'b1, 8'd3,   8'd3, 1'b1, 1'b1, 12'd12,   4'd5, 4'd8},
    '{1'b0, 8'd3,   8'd3, 1'b1, 1'b0, 12'd12,   4'd6, 4'd8},
    '{1'b1, 8'd3,   8'd3, 1'b1, 1'b0, 12'd2,    4'd5, 4'd8},
    '{1'b0, 8'd3,   8'd3, 1'b1, 1'b0, 12'd12,   4'd6, 4'd8}, // broken run
    '{1'b1, 8'd0,   8'd2, 1'b0, 1'b0, 12'd2,    4'd5, 4'd4}, // R4
    '{1'b1, 8'd0,   8'd2, 1'b0, 1'b1, 12'd2,    4'd5, 4'd4},
    '{1'b0, 8'd1,   8'd0, 1'b0, 1'b0, 12'd4,    4'd6, 4'd3},
    '{1'b1, 8'd1,   8'd0, 1'b0, 1'b1, 12'd4,    4'd7, 4'd3}, // R7
    '{1'b1, 8'd1,   8'd1, 1'b1, 1'b1, 12'd4,    4'd7, 4'd8},
    '{1'b0, 8'd1,   8'd1, 1'b1, 1'b0, 12'd4,    4'd6, 4'd8},
    '{1'b0, 8'd255, 8'd3, 1'b0, 1'b0, 12'd1020, 4'd6, 4'd3}, // max SC
    '{1'b1, 8'd255, 8'd2, 1'b1, 1'b0, 12'd2,    4'd5, 4'd8},
    '{1'b1, 8'd1,   8'd2, 1'b1, 1'b1, 12'd4,    4'd5, 4'd8},
    '{1'b0, 8'd1,   8'd2, 1'b1, 1'b0, 12'd4,    4'd6, 4'd8}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       burst_done = 1'b0;
  logic       over_thr = 1'b0;
  logic [7:0] sc_cfg = 8'd1;
  logic [7:0] dit_cfg = 8'd1;
  logic       fast_cfg = 1'b0;
  logic       burst_req, det_out;

  int total = 0;
  int bad = 0;
  int tick_total = 0;
  logic cnt_en = 1'b0;
  int tdiv = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    tdiv = (tdiv + 1) % 3;
    tick <= (tdiv == 0);
  end

  always @(posedge clk) if (cnt_en && tick) tick_total <= tick_total + 1;

  acq_burst_confirm #(.SLEEP_TICKS(SLEEP), .GAP_TICKS(GAP)) i_acq_burst_confirm (
    .clk(clk), .rst_n(rst_n), .tick(tick), .burst_done(burst_done),
    .over_thr(over_thr), .sc_cfg(sc_cfg), .dit_cfg(dit_cfg), .fast_cfg(fast_cfg),
    .burst_req(burst_req), .det_out(det_out)
  );

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  // one burst: result with verdict, then count ticks until the next request
  task automatic run_burst(input logic ov, input logic [7:0] sc, input logic [7:0] dit,
                           input logic fst, input logic exp_out, input int exp_gap,
                           input string rq_o, input string rq_g, input bit stray);
    int start;
    int gap;
    bit seen;
    repeat (2) @(negedge clk);
    over_thr = ov; sc_cfg = sc; dit_cfg = dit; fast_cfg = fst; burst_done = 1'b1;
    @(negedge clk);
    burst_done = 1'b0;
    chk(det_out == exp_out, rq_o, det_out, exp_out);
    start = tick_total;
    cnt_en = 1'b1;
    seen = 1'b0;
    for (int k = 0; k < 10000; k++) begin
      if (stray && k == 5) begin
        over_thr = 1'b1; dit_cfg = 8'd1; burst_done = 1'b1;
      end else if (stray && k == 6) begin
        burst_done = 1'b0; over_thr = ov; dit_cfg = dit;
        chk(det_out == exp_out, "R9 stray done", det_out, exp_out);
      end
      @(negedge clk);
      if (burst_req) begin seen = 1'b1; break; end
    end
    cnt_en = 1'b0;
    gap = tick_total - start;
    chk(seen, rq_g, 0, 1);
    chk(gap == exp_gap, rq_g, gap, exp_gap);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++; total++;
    $display("FAIL watchdog: actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(det_out == 1'b0, "R1 reset out", det_out, 0);
    chk(burst_req == 1'b0, "R1 reset req", burst_req, 0);
    rst_n = 1'b1;
    @(negedge clk);  // IDLE -> REQ edge
    chk(burst_req == 1'b1, "R1 first req", burst_req, 1);
    @(negedge clk);
    chk(burst_req == 1'b0, "R2 one-cycle req", burst_req, 0);
    begin
      int extra = 0;
      for (int k = 0; k < 60; k++) begin
        @(negedge clk);
        if (burst_req) extra++;
      end
      chk(extra == 0, "R2 no req while outstanding", extra, 0);
    end

    for (int i = 0; i < NV; i++) begin
      run_burst(VEC[i].over, VEC[i].sc, VEC[i].dit, VEC[i].fast, VEC[i].out,
                int'(VEC[i].gap), $sformatf("R%0d vec %0d out", VEC[i].rq_out, i),
                $sformatf("R%0d vec %0d gap", VEC[i].rq_gap, i), 1'b0);
    end

    // R9: stray done during the wait leaves output and wait length alone
    run_burst(1'b0, 8'd2, 8'd3, 1'b0, 1'b0, 8, "R6 pre-stray", "R9 gap kept", 1'b1);
    run_burst(1'b1, 8'd1, 8'd1, 1'b0, 1'b1, 4, "R7 before reset", "R3", 1'b0);

    // R1: reset mid-run clears the output
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(det_out == 1'b0, "R1 reset clears out", det_out, 0);
    chk(burst_req == 1'b0, "R1 reset clears req", burst_req, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(burst_req == 1'b1, "R1 req after re-reset", burst_req, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule